// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible storage of an interrupt router. Software reaches every register through a pair of bus locations: a select register picks an internal register, and a data window reads or writes the picked register. Behind the window sit a 4-bit device identifier, a read-only version word and a table with one 64-bit redirection entry per interrupt pin. Each table entry is reached as two 32-bit halves. The full table is driven out in parallel to the delivery logic, which decodes the fields of each entry.

The delivery logic owns two status bits of each entry: the delivery-status bit and the pending-acknowledge (remote-IRR) bit. It sets them through a separate status port, and bus writes never change them. The one exception is that a bus write which leaves an entry in edge mode clears its remote-IRR bit. After every accepted table write the block sends a one-cycle update strobe that carries the entry index and a flag showing whether the mask bit changed. The delivery logic uses it to re-evaluate that entry.

Bus handling is built around a three-state access machine. ACC_IDLE means no response is due. ACC_READ means read data is valid this cycle. ACC_WRITE means the update strobe is out this cycle. The machine moves to ACC_WRITE after a table write is accepted, to ACC_READ after a read strobe without a write, and to ACC_IDLE otherwise. Any state can move to any other state on each cycle.

Top module: `irq_route_regfile`

## Requirements
- R1: A bus write at offset 0x00 loads the select register with the low 8 bits of the data. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R2: Offset 0x10 is the data window. A read at any offset other than 0x00 and 0x10 returns zero, and a write there changes no register.
- R3: Select 0x01 reads the version word: NUM_PINS-1 in bits 23:16, VERSION in bits 7:0, all other bits zero. Writes to select 0x01 change nothing.
- R4: A window write with select 0x00 stores data bits 27:24 as the ID. Window reads with select 0x00 or 0x02 return the ID in bits 27:24 with all other bits zero. Window writes with select 0x02 change nothing.
- R5: For a select S of 0x10 or above, the entry index is (S-0x10)>>1. An odd S reaches bits 63:32 of the entry and an even S reaches bits 31:0. Entry i is driven on tbl_flat[64i+63:64i].
- R6: A select of 0x03 to 0x0F, or a select that maps to an index of NUM_PINS or above, reads as 0xFFFFFFFF. Writes to such a select change no entry and produce no update strobe.
- R7: A bus table write leaves bit 12 (delivery status) and bit 14 (remote-IRR) of the entry at their previous values, whatever the written data holds.
- R8: After a bus table write, if bit 15 (trigger mode, 1 = level, 0 = edge) of the entry is 0, bit 14 is 0.
- R9: After reset every entry holds only bit 16 (mask) set, and the select and ID registers are zero.
- R10: In the cycle after each accepted table write, upd_valid is high for one cycle and upd_index carries the entry index. upd_mask_chg is high in that cycle exactly when bit 16 of the entry changed.
- R11: Read data and bus_rvalid appear in the cycle after a read strobe, and bus_rvalid lasts one cycle. When bus_wr and bus_rd are high together, the write is performed and the read is dropped.
- R12: A status write (sts_we) with an index below NUM_PINS loads bits 14 and 12 of that entry from sts_remote_irr and sts_deliv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| sts_we | input | 1 | Status update from the delivery logic |
| sts_idx | input | IDX_W | Entry index of the status update |
| sts_remote_irr | input | 1 | New remote-IRR value |
| sts_deliv | input | 1 | New delivery-status value |
| tbl_flat | output | 64*NUM_PINS | All entries, entry i at bits 64i+63:64i |
| upd_valid | output | 1 | Entry-updated strobe |
| upd_index | output | IDX_W | Index of the updated entry |
| upd_mask_chg | output | 1 | Mask bit changed by that update |

## Verification
The bench builds the block with NUM_PINS = 5 and VERSION = 0x11. With only five pins, all 256 select values can be swept through the window. The sweep covers the special registers, every entry half, the unmapped selects below 0x10, and the out-of-range indexes from 5 upward. Because five is not a power of two, the range check is tested on an index width that would otherwise alias. Each entry gets several bus patterns in both halves. The status port then drives remote-IRR and delivery status on one entry, so the preserve and edge-clear rules act on ones as well as zeros.

// File: rtl/irq_rrf_pkg.sv
package irq_rrf_pkg;

    // Bus offsets
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // Select values for the special registers
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL0 = 8'h10;

    // Entry bit positions decoded by the delivery logic
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    localparam logic [63:0] ENTRY_RST = 64'(1) << B_MASK;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_TBL,
        K_NONE
    } sel_kind_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_state_t;

endpackage

// File: rtl/irq_rrf_sel_decode.sv
module irq_rrf_sel_decode
    import irq_rrf_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       sel,
    output sel_kind_t        kind,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);

    logic [7:0] off;
    logic [6:0] slot;

    always_comb begin
        off   = sel - SEL_TBL0;
        slot  = off[7:1];
        upper = sel[0];
        idx   = slot[IDX_W-1:0];
        if (sel == SEL_ID) begin
            kind = K_ID;
        end else if (sel == SEL_VER) begin
            kind = K_VER;
        end else if (sel == SEL_ARB) begin
            kind = K_ARB;
        end else if ((sel >= SEL_TBL0) && (slot < 7'(NUM_PINS))) begin
            kind = K_TBL;
        end else begin
            kind = K_NONE;
        end
    end

endmodule

// File: rtl/irq_rrf_entry.sv
module irq_rrf_entry
    import irq_rrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        upper,
    input  logic [31:0] wdata,
    input  logic        sts_we,
    input  logic        sts_rirr,
    input  logic        sts_dstat,
    output logic [63:0] q,
    output logic        mask_chg
);

    logic [63:0] merged;
    logic [63:0] nxt;

    always_comb begin
        merged = upper ? {wdata, q[31:0]} : {q[63:32], wdata};
        merged[B_DSTAT] = q[B_DSTAT];
        merged[B_RIRR]  = q[B_RIRR];
        nxt = bus_we ? merged : q;
        if (sts_we) begin
            nxt[B_DSTAT] = sts_dstat;
            nxt[B_RIRR]  = sts_rirr;
        end
        if (bus_we && !nxt[B_TRIG]) begin
            nxt[B_RIRR] = 1'b0;
        end
        mask_chg = bus_we && (nxt[B_MASK] != q[B_MASK]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ENTRY_RST;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_rrf_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h11,
    localparam int         IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic                    sts_we,
    input  logic [IDX_W-1:0]        sts_idx,
    input  logic                    sts_remote_irr,
    input  logic                    sts_deliv,
    output logic [64*NUM_PINS-1:0]  tbl_flat,
    output logic                    upd_valid,
    output logic [IDX_W-1:0]        upd_index,
    output logic                    upd_mask_chg
);

    localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

    acc_state_t       state, nxt_state;
    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [31:0]      rdata_q;
    logic [IDX_W-1:0] upd_idx_q;
    logic             mchg_q;

    sel_kind_t        kind;
    logic [IDX_W-1:0] idx;
    logic             upper;

    logic             sel_hit, win_hit, do_wr, do_rd, tbl_we;
    logic [31:0]      rd_word;
    logic [63:0]      ent_q [NUM_PINS];
    logic [NUM_PINS-1:0] mchg_vec;

    irq_rrf_sel_decode #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .sel   (sel_q),
        .kind  (kind),
        .idx   (idx),
        .upper (upper)
    );

    assign sel_hit = (bus_addr == OFF_SEL);
    assign win_hit = (bus_addr == OFF_WIN);
    assign do_wr   = bus_wr;
    assign do_rd   = bus_rd && !bus_wr;
    assign tbl_we  = do_wr && win_hit && (kind == K_TBL);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        irq_rrf_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_we    (tbl_we && (idx == IDX_W'(g))),
            .upper     (upper),
            .wdata     (bus_wdata),
            .sts_we    (sts_we && (sts_idx == IDX_W'(g))),
            .sts_rirr  (sts_remote_irr),
            .sts_dstat (sts_deliv),
            .q         (ent_q[g]),
            .mask_chg  (mchg_vec[g])
        );
        assign tbl_flat[64*g +: 64] = ent_q[g];
    end

    // Read data selection
    always_comb begin
        rd_word = '0;
        if (sel_hit) begin
            rd_word = {24'h0, sel_q};
        end else if (win_hit) begin
            unique case (kind)
                K_ID, K_ARB: rd_word = {4'h0, id_q, 24'h0};
                K_VER:       rd_word = {8'h0, PIN_MAX, 8'h0, VERSION};
                K_TBL:       rd_word = upper ? ent_q[idx][63:32] : ent_q[idx][31:0];
                default:     rd_word = '1;
            endcase
        end
    end

    // Register writes outside the table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (do_wr) begin
            if (sel_hit) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_hit && (kind == K_ID)) begin
                id_q <= bus_wdata[27:24];
            end
        end
    end

    // Response payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            upd_idx_q <= '0;
            mchg_q    <= 1'b0;
        end else begin
            if (do_rd) begin
                rdata_q <= rd_word;
            end
            if (tbl_we) begin
                upd_idx_q <= idx;
                mchg_q    <= |mchg_vec;
            end
        end
    end

    // Access state machine: next state
    always_comb begin
        unique case ({tbl_we, do_rd})
            2'b10:   nxt_state = ACC_WRITE;
            2'b01:   nxt_state = ACC_READ;
            default: nxt_state = ACC_IDLE;
        endcase
    end

    // Access state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACC_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Access state machine: outputs
    always_comb begin
        bus_rvalid   = 1'b0;
        upd_valid    = 1'b0;
        unique case (state)
            ACC_READ:  bus_rvalid = 1'b1;
            ACC_WRITE: upd_valid  = 1'b1;
            default:   ;
        endcase
        bus_rdata    = rdata_q;
        upd_index    = upd_idx_q;
        upd_mask_chg = upd_valid && mchg_q;
    end

endmodule

// File: rtl/irq_rrf_checker.sv
module irq_rrf_checker #(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_addr,
    input logic [31:0]            bus_rdata,
    input logic                   bus_rvalid,
    input logic                   sts_we,
    input logic [64*NUM_PINS-1:0] tbl_flat,
    input logic                   upd_valid,
    input logic [IDX_W-1:0]       upd_index,
    input logic                   upd_mask_chg
);

    logic [NUM_PINS-1:0] dstat_vec, rirr_vec, trig_vec;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_vec
        assign dstat_vec[g] = tbl_flat[64*g + 12];
        assign rirr_vec[g]  = tbl_flat[64*g + 14];
        assign trig_vec[g]  = tbl_flat[64*g + 15];
    end

    assert_read_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    assert_ack_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd && !bus_wr));

    assert_upd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(bus_wr && (bus_addr == 8'h10)));

    assert_mchg_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_mask_chg |-> upd_valid);

    assert_edge_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !trig_vec[upd_index]) |-> !rirr_vec[upd_index]);

    assert_dstat_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sts_we) |-> $stable(dstat_vec));

    assert_sel_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && ($past(bus_addr) == 8'h00)) |-> (bus_rdata[31:8] == 24'h0));

    assert_other_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && ($past(bus_addr) != 8'h00) && ($past(bus_addr) != 8'h10))
        |-> (bus_rdata == 32'h0));

endmodule

bind irq_route_regfile irq_rrf_checker #(
    .NUM_PINS (NUM_PINS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .sts_we       (sts_we),
    .tbl_flat     (tbl_flat),
    .upd_valid    (upd_valid),
    .upd_index    (upd_index),
    .upd_mask_chg (upd_mask_chg)
);

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         NP         = 5;
    localparam int         IW         = 3;
    localparam logic [7:0] VER        = 8'h11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid;
    logic             sts_we = 1'b0;
    logic [IW-1:0]    sts_idx = '0;
    logic             sts_remote_irr = 1'b0;
    logic             sts_deliv = 1'b0;
    logic [64*NP-1:0] tbl_flat;
    logic             upd_valid;
    logic [IW-1:0]    upd_index;
    logic             upd_mask_chg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [63:0] model [NP];
    logic [3:0]  model_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_regfile #(
        .NUM_PINS (NP),
        .VERSION  (VER)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bus_rvalid     (bus_rvalid),
        .sts_we         (sts_we),
        .sts_idx        (sts_idx),
        .sts_remote_irr (sts_remote_irr),
        .sts_deliv      (sts_deliv),
        .tbl_flat       (tbl_flat),
        .upd_valid      (upd_valid),
        .upd_index      (upd_index),
        .upd_mask_chg   (upd_mask_chg)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Both tasks return at the falling edge after the sampling rising edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input bit also_rd = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = also_rd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R11 rvalid after read", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        bus_write(8'h00, 32'(s));
        bus_read(8'h10, d);
    endtask

    function automatic logic [63:0] apply_wr(input logic [63:0] old, input bit up, input logic [31:0] d);
        logic [63:0] n;
        n = up ? {d, old[31:0]} : {old[63:32], d};
        n[12] = old[12];
        n[14] = old[14];
        if (!n[15]) n[14] = 1'b0;
        return n;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] s);
        int ix;
        if (s == 8'h00 || s == 8'h02) return {4'h0, model_id, 24'h0};
        if (s == 8'h01) return {8'h0, 8'(NP - 1), 8'h0, VER};
        if (s < 8'h10) return 32'hFFFF_FFFF;
        ix = (int'(s) - 16) >> 1;
        if (ix >= NP) return 32'hFFFF_FFFF;
        return s[0] ? model[ix][63:32] : model[ix][31:0];
    endfunction

    task automatic check_table(input string req);
        for (int i = 0; i < NP; i++) begin
            chk(req, tbl_flat[64*i +: 64], model[i]);
        end
    endtask

    task automatic tbl_write(input int i, input bit up, input logic [31:0] d);
        logic [63:0] old;
        old = model[i];
        model[i] = apply_wr(old, up, d);
        bus_write(8'h00, 32'(16 + 2*i + int'(up)));
        bus_write(8'h10, d);
        chk("R10 upd_valid", 64'(upd_valid), 64'd1);
        chk("R10 upd_index", 64'(upd_index), 64'(i));
        chk("R10 upd_mask_chg", 64'(upd_mask_chg), 64'(model[i][16] != old[16]));
        @(negedge clk);
        chk("R10 strobe one cycle", 64'(upd_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pats [4];
        for (int i = 0; i < NP; i++) model[i] = 64'(1) << 16;
        model_id = 4'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 rvalid idle", 64'(bus_rvalid), 64'd0);
        chk("R9 upd idle", 64'(upd_valid), 64'd0);
        check_table("R9 entry reset value");
        bus_read(8'h00, rd);
        chk("R9 select cleared", 64'(rd), 64'd0);
        @(negedge clk);
        chk("R11 rvalid one cycle", 64'(bus_rvalid), 64'd0);

        // R3 R4 R5 R6: sweep every select value
        for (int s = 0; s < 256; s++) begin
            win_read(8'(s), rd);
            chk("R5 R6 sweep read", 64'(rd), 64'(exp_read(8'(s))));
        end

        // R1: select keeps only the low byte
        bus_write(8'h00, 32'h1234_5678);
        bus_read(8'h00, rd);
        chk("R1 select low byte", 64'(rd), 64'h78);

        // R4: ID register
        bus_write(8'h00, 32'h0);
        bus_write(8'h10, 32'hA5FF_FFFF);
        model_id = 4'h5;
        win_read(8'h00, rd);
        chk("R4 id read", 64'(rd), 64'h0500_0000);
        win_read(8'h02, rd);
        chk("R4 arb read", 64'(rd), 64'h0500_0000);
        bus_write(8'h00, 32'h2);
        bus_write(8'h10, 32'h0F00_0000);
        win_read(8'h00, rd);
        chk("R4 arb write ignored", 64'(rd), 64'h0500_0000);

        // R3: version write ignored
        bus_write(8'h00, 32'h1);
        bus_write(8'h10, 32'hFFFF_FFFF);
        win_read(8'h01, rd);
        chk("R3 version unchanged", 64'(rd), 64'(exp_read(8'h01)));

        // R5 R7 R8 R10: table write patterns per entry and half
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h0000_0000;
        pats[2] = 32'h0001_A0C3;
        pats[3] = 32'h0000_DA5A;
        for (int i = 0; i < NP; i++) begin
            for (int k = 0; k < 4; k++) begin
                tbl_write(i, 1'b0, pats[k] ^ 32'(i << 4));
                tbl_write(i, 1'b1, ~pats[k] ^ 32'(i));
                win_read(8'(16 + 2*i), rd);
                chk("R5 lower half", 64'(rd), 64'(model[i][31:0]));
                win_read(8'(17 + 2*i), rd);
                chk("R5 upper half", 64'(rd), 64'(model[i][63:32]));
            end
        end
        check_table("R5 table after sweep");

        // R12: status port sets both status bits of entry 2
        @(negedge clk);
        sts_we = 1'b1; sts_idx = 3'd2; sts_remote_irr = 1'b1; sts_deliv = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        model[2][12] = 1'b1;
        model[2][14] = 1'b1;
        chk("R12 status bits set", 64'(tbl_flat[64*2 +: 64]), model[2]);

        // R7: level-mode write with status bits clear in data keeps them
        tbl_write(2, 1'b0, 32'h0000_8031);
        chk("R7 remote-irr kept", 64'(tbl_flat[64*2 + 14]), 64'd1);
        chk("R7 delivery status kept", 64'(tbl_flat[64*2 + 12]), 64'd1);

        // R8: edge-mode write clears remote-irr, delivery status stays
        tbl_write(2, 1'b0, 32'h0001_5031);
        chk("R8 remote-irr cleared", 64'(tbl_flat[64*2 + 14]), 64'd0);
        chk("R7 delivery status kept edge", 64'(tbl_flat[64*2 + 12]), 64'd1);
        check_table("R8 table");

        // R6: writes to unmapped or out-of-range selects
        foreach (pats[k]) begin
            logic [7:0] bad [4];
            bad[0] = 8'd26; bad[1] = 8'd27; bad[2] = 8'h05; bad[3] = 8'hFF;
            bus_write(8'h00, 32'(bad[k]));
            bus_write(8'h10, 32'hFFFF_FFFF);
            chk("R6 no strobe", 64'(upd_valid), 64'd0);
        end
        check_table("R6 table unchanged");
        win_read(8'h00, rd);
        chk("R6 id unchanged", 64'(rd), 64'h0500_0000);

        // R2: other offsets
        bus_write(8'h00, 32'h11);
        bus_write(8'h04, 32'h0000_0022);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h00, rd);
        chk("R2 select unchanged", 64'(rd), 64'h11);
        bus_read(8'h04, rd);
        chk("R2 offset 04 reads zero", 64'(rd), 64'd0);
        bus_read(8'h30, rd);
        chk("R2 offset 30 reads zero", 64'(rd), 64'd0);
        check_table("R2 table unchanged");

        // R11: simultaneous write and read
        bus_write(8'h00, 32'h12);
        model[1] = apply_wr(model[1], 1'b0, 32'h0000_0077);
        bus_write(8'h10, 32'h0000_0077, 1'b1);
        chk("R11 read dropped", 64'(bus_rvalid), 64'd0);
        chk("R11 write done", 64'(upd_valid), 64'd1);
        chk("R11 entry written", 64'(tbl_flat[64*1 +: 64]), model[1]);

        done = 1'b1;
        report();
    end

endmodule